// File: doc/BRIEF.md
# UART Receive Queue with Per-Character Error Tags

This block is the receive-side character buffer of one serial channel. The receiver front end hands it one byte at a time. With each byte come three line-error indications: parity mismatch, bad stop bit, and break. The buffer stores all eleven bits as a single entry and keeps up to 32 entries in arrival order. When software reads a character, it can therefore see exactly which character was damaged.

The host reaches the buffer through a small register read port with four addresses:

- Address 0 pops the oldest character.
- Address 1 returns a line-status byte that describes the oldest character and the overrun state.
- Address 2 returns the fill level.
- Address 3 returns the trigger in force.

The fill level is also a direct output. It is compared with two thresholds:

- An interrupt threshold produces a data-available condition. This threshold is either a freely programmed value or one of four values picked by a legacy 2-bit select.
- A separate flow threshold drives an active-high ready-to-send output.

A clear input flushes the buffer in one cycle.

Top module: `rx_tagged_fifo`

## Requirements
- R1: After the synchronous reset the level is 0, `data_avail` is low, `rts` is high (for a non-zero `flow_trig`), `rd_data` is 0 and the overrun flag is 0.
- R2: A read at address 0 returns, one cycle later on `rd_data`, the data byte of the oldest entry and removes that entry. Entries come out in the order they were pushed.
- R3: `level` always equals the number of stored entries, is never above 32, and is also returned by a read at address 2.
- R4: A push while the buffer holds 32 entries and no pop happens in the same cycle is dropped. The stored contents and level are unchanged, and the overrun flag is set.
- R5: The overrun flag is line-status bit 1 and is cleared by a read at address 1. If a new overrun happens in the same cycle as that read, the flag stays set.
- R6: A read at address 0 on an empty buffer returns 0x00 and leaves the level unchanged.
- R7: A push and a pop in the same cycle on a full buffer are both carried out, and the level stays 32.
- R8: When `trig_prog_en` is 0, the interrupt threshold is set by `trig_legacy`: 0 selects 1, 1 selects 8, 2 selects 16 and 3 selects 28. The threshold in force is readable at address 3.
- R9: When `trig_prog_en` is 1, the threshold is `int_trig`, and a value of 0 acts as 1. In both R8 and R9 modes, `data_avail` is high exactly while level >= threshold.
- R10: `rts` is high exactly while level < `flow_trig`. It drops when the level reaches the flow threshold and rises again once the level falls below it.
- R11: `fifo_clr` empties the buffer in one cycle. It takes priority over a push or pop in the same cycle and does not change the overrun flag.
- R12: Line-status bits 2, 3 and 4 show the parity, framing and break flags of the oldest entry. Bit 0 is high when the buffer is not empty, and bits 7..5 are 0. The flags move to the next entry after a pop and read 0 when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_clr | input | 1 | Flush all stored entries |
| push_valid | input | 1 | Receiver delivers a character this cycle |
| push_data | input | 8 | Received character |
| push_par | input | 1 | Parity error on this character |
| push_frm | input | 1 | Framing error on this character |
| push_brk | input | 1 | Break detected on this character |
| rd_en | input | 1 | Host register read strobe |
| rd_addr | input | 2 | 0 data/pop, 1 line status, 2 level, 3 trigger in force |
| rd_data | output | 8 | Registered read result, valid the cycle after `rd_en` |
| trig_legacy | input | 2 | Legacy threshold select |
| trig_prog_en | input | 1 | Use `int_trig` instead of the legacy select |
| int_trig | input | 6 | Programmed interrupt threshold |
| flow_trig | input | 6 | Flow-control threshold |
| level | output | 6 | Current number of stored entries |
| data_avail | output | 1 | Level at or above the interrupt threshold |
| rts | output | 1 | Ready to send, high while level is below the flow threshold |

## Verification
The bound checker watches several properties on every cycle:

- The level never exceeds the depth, and it moves by at most one entry per cycle except on a flush.
- A flush always leaves the buffer empty.
- A push into a full buffer is dropped and raises overrun.
- A status read clears overrun.
- A data read on an empty buffer changes nothing.
- `rts` tracks the flow threshold.

Other behaviour needs the bench's scenarios and its queue model:

- That each popped byte carries the flags it arrived with.
- The strict arrival order.
- The legacy threshold table.
- Overrun persisting across a flush.
- The set-wins case when an overrun coincides with a status read.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // One stored character together with its line-error tags
    typedef struct packed {
        logic       brk;
        logic       frm;
        logic       par;
        logic [7:0] data;
    } rx_entry_t;

    // Host read-port addresses
    typedef enum logic [1:0] {
        REG_RXDATA = 2'd0,
        REG_LSTAT  = 2'd1,
        REG_LEVEL  = 2'd2,
        REG_TRIG   = 2'd3
    } rd_reg_e;

    // Thresholds selected by the legacy 2-bit field, scaled to the depth
    function automatic int legacy_trig(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 4;
        endcase
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push_req,
    input  rx_entry_t        push_entry,
    input  logic             pop_req,
    output rx_entry_t        head,
    output logic [LVL_W-1:0] count,
    output logic             drop
);

    rx_entry_t      mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic           pop_ok;
    logic           push_ok;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        pop_ok  = pop_req && (count != '0);
        push_ok = push_req && ((count != LVL_W'(DEPTH)) || pop_ok);
        drop    = push_req && !push_ok && !clr;
    end

    assign head = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= push_entry;
                wr_ptr      <= adv(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= adv(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic [LVL_W-1:0] count,
    input  logic             prog_en,
    input  logic [1:0]       legacy_sel,
    input  logic [LVL_W-1:0] int_trig,
    input  logic [LVL_W-1:0] flow_trig,
    output logic [LVL_W-1:0] eff_trig,
    output logic             data_avail,
    output logic             rts
);

    logic [LVL_W-1:0] legacy_val;

    always_comb begin
        legacy_val = LVL_W'(legacy_trig(legacy_sel, DEPTH));
        if (prog_en) begin
            eff_trig = (int_trig == '0) ? LVL_W'(1) : int_trig;
        end else begin
            eff_trig = legacy_val;
        end
        data_avail = (count >= eff_trig);
        rts        = (count < flow_trig);
    end

endmodule

// File: rtl/rxq_regport.sv
module rxq_regport
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    input  rx_entry_t        head,
    input  logic [LVL_W-1:0] count,
    input  logic [LVL_W-1:0] eff_trig,
    input  logic             drop,
    output logic             pop_req,
    output logic             ovr_flag,
    output logic [7:0]       rd_data
);

    rd_reg_e    sel;
    logic       has_data;
    logic [7:0] lstat;
    logic [7:0] mux;
    logic       lstat_rd;

    always_comb begin
        sel      = rd_reg_e'(rd_addr);
        has_data = (count != '0);
        pop_req  = rd_en && (sel == REG_RXDATA);
        lstat_rd = rd_en && (sel == REG_LSTAT);
        lstat    = {3'b000,
                    head.brk & has_data,
                    head.frm & has_data,
                    head.par & has_data,
                    ovr_flag,
                    has_data};
        case (sel)
            REG_RXDATA: mux = has_data ? head.data : 8'h00;
            REG_LSTAT:  mux = lstat;
            REG_LEVEL:  mux = 8'(count);
            default:    mux = 8'(eff_trig);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            ovr_flag <= 1'b0;
        end else begin
            if (rd_en) begin
                rd_data <= mux;
            end
            if (drop) begin
                ovr_flag <= 1'b1;
            end else if (lstat_rd) begin
                ovr_flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
    import rxq_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_clr,
    input  logic             push_valid,
    input  logic [7:0]       push_data,
    input  logic             push_par,
    input  logic             push_frm,
    input  logic             push_brk,
    input  logic             rd_en,
    input  logic [1:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic [1:0]       trig_legacy,
    input  logic             trig_prog_en,
    input  logic [LVL_W-1:0] int_trig,
    input  logic [LVL_W-1:0] flow_trig,
    output logic [LVL_W-1:0] level,
    output logic             data_avail,
    output logic             rts
);

    rx_entry_t        in_entry;
    rx_entry_t        head;
    logic             pop_req;
    logic             drop;
    logic             ovr_flag;
    logic [LVL_W-1:0] eff_trig;

    assign in_entry = '{brk: push_brk, frm: push_frm, par: push_par, data: push_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .clr        (fifo_clr),
        .push_req   (push_valid),
        .push_entry (in_entry),
        .pop_req    (pop_req),
        .head       (head),
        .count      (level),
        .drop       (drop)
    );

    rxq_thresh #(.DEPTH(DEPTH)) u_thresh (
        .count      (level),
        .prog_en    (trig_prog_en),
        .legacy_sel (trig_legacy),
        .int_trig   (int_trig),
        .flow_trig  (flow_trig),
        .eff_trig   (eff_trig),
        .data_avail (data_avail),
        .rts        (rts)
    );

    rxq_regport #(.DEPTH(DEPTH)) u_regport (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .head     (head),
        .count    (level),
        .eff_trig (eff_trig),
        .drop     (drop),
        .pop_req  (pop_req),
        .ovr_flag (ovr_flag),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter  int DEPTH = 32,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_clr,
    input logic             push_valid,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic [LVL_W-1:0] level,
    input logic [LVL_W-1:0] flow_trig,
    input logic             rts,
    input logic             ovr
);

    // R3
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(level) <= DEPTH);

    // R3
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        !fifo_clr |=> (int'(level) <= int'($past(level)) + 1) &&
                      (int'(level) + 1 >= int'($past(level))));

    // R11
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_clr |=> level == '0);

    // R4
    overflow_drop_chk: assert property (@(posedge clk) disable iff (rst)
        push_valid && (int'(level) == DEPTH) && !(rd_en && rd_addr == 2'd0) && !fifo_clr
        |=> ovr && (int'(level) == DEPTH));

    // R5
    ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 2'd1 && !(push_valid && int'(level) == DEPTH)
        |=> !ovr);

    // R6
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en && rd_addr == 2'd0 && level == '0 && !push_valid && !fifo_clr
        |=> level == '0);

    // R10
    rts_level_chk: assert property (@(posedge clk) disable iff (rst)
        rts == (level < flow_trig));

endmodule

bind rx_tagged_fifo rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_clr   (fifo_clr),
    .push_valid (push_valid),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .level      (level),
    .flow_trig  (flow_trig),
    .rts        (rts),
    .ovr        (ovr_flag)
);

// File: tb/tb_rx_tagged_fifo.sv
module tb_rx_tagged_fifo;

    localparam int DEPTH = 32;
    localparam int LVL_W = 6;

    logic             clk = 1'b0;
    logic             rst;
    logic             fifo_clr;
    logic             push_valid;
    logic [7:0]       push_data;
    logic             push_par, push_frm, push_brk;
    logic             rd_en;
    logic [1:0]       rd_addr;
    logic [7:0]       rd_data;
    logic [1:0]       trig_legacy;
    logic             trig_prog_en;
    logic [LVL_W-1:0] int_trig;
    logic [LVL_W-1:0] flow_trig;
    logic [LVL_W-1:0] level;
    logic             data_avail;
    logic             rts;

    rx_tagged_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .fifo_clr(fifo_clr),
        .push_valid(push_valid), .push_data(push_data),
        .push_par(push_par), .push_frm(push_frm), .push_brk(push_brk),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .trig_legacy(trig_legacy), .trig_prog_en(trig_prog_en),
        .int_trig(int_trig), .flow_trig(flow_trig),
        .level(level), .data_avail(data_avail), .rts(rts)
    );

    always #4 clk = ~clk;

    // Behavioural reference: entries are {brk,frm,par,data}
    logic [10:0] mq[$];
    bit          m_ovr;
    logic [7:0]  m_rd;
    int          errors = 0;
    int          checks = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff_trig();
        if (trig_prog_en) return (int_trig == 0) ? 1 : int'(int_trig);
        case (trig_legacy)
            2'd0:    return 1;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 28;
        endcase
    endfunction

    // One clock: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input bit p, input logic [7:0] d, input logic [2:0] f,
                       input bit rd, input logic [1:0] a, input bit c, input string tag);
        int          sz;
        bit          pop_ok;
        bit          push_ok;
        bit          drop;
        logic [10:0] hd;
        push_valid = p; push_data = d; {push_brk, push_frm, push_par} = f;
        rd_en = rd; rd_addr = a; fifo_clr = c;
        @(posedge clk);
        sz = mq.size();
        hd = (sz != 0) ? mq[0] : 11'd0;
        drop = 1'b0;
        if (rd) begin
            case (a)
                2'd0:    m_rd = (sz != 0) ? hd[7:0] : 8'h00;
                2'd1:    m_rd = {3'b000, hd[10:8], m_ovr, sz != 0};
                2'd2:    m_rd = 8'(sz);
                default: m_rd = 8'(eff_trig());
            endcase
        end
        if (c) begin
            mq.delete();
        end else begin
            pop_ok  = rd && a == 2'd0 && sz > 0;
            push_ok = p && (sz < DEPTH || pop_ok);
            drop    = p && !push_ok;
            if (pop_ok)  void'(mq.pop_front());
            if (push_ok) mq.push_back({f, d});
        end
        if (drop) m_ovr = 1'b1;
        else if (rd && a == 2'd1) m_ovr = 1'b0;
        @(negedge clk);
        push_valid = 1'b0; rd_en = 1'b0; fifo_clr = 1'b0;
        chk(int'(level) == mq.size(), "R3", int'(level), mq.size());
        chk(data_avail == (mq.size() >= eff_trig()), trig_prog_en ? "R9" : "R8",
            int'(data_avail), int'(mq.size() >= eff_trig()));
        chk(rts == (mq.size() < int'(flow_trig)), "R10", int'(rts),
            int'(mq.size() < int'(flow_trig)));
        if (rd) chk(rd_data == m_rd, tag, int'(rd_data), int'(m_rd));
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f, input string tag);
        cyc(1'b1, d, f, 1'b0, 2'd0, 1'b0, tag);
    endtask

    task automatic rdreg(input logic [1:0] a, input string tag);
        cyc(1'b0, 8'h00, 3'b000, 1'b1, a, 1'b0, tag);
    endtask

    task automatic flush(input string tag);
        cyc(1'b0, 8'h00, 3'b000, 1'b0, 2'd0, 1'b1, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; fifo_clr = 0; push_valid = 0; push_data = 0;
        push_par = 0; push_frm = 0; push_brk = 0; rd_en = 0; rd_addr = 0;
        trig_legacy = 2'd0; trig_prog_en = 0; int_trig = 0; flow_trig = 6'd24;
        m_ovr = 0; m_rd = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(level == 0, "R1", int'(level), 0);
        chk(data_avail == 0, "R1", int'(data_avail), 0);
        chk(rts == 1, "R1", int'(rts), 1);
        chk(rd_data == 0, "R1", int'(rd_data), 0);
        rdreg(2'd1, "R1");

        // R2 / R12: tagged entries come out in order with their flags
        push(8'h41, 3'b000, "R2");
        push(8'h52, 3'b001, "R2");
        push(8'h63, 3'b010, "R2");
        push(8'h74, 3'b100, "R2");
        for (int i = 0; i < 4; i++) begin
            rdreg(2'd1, "R12");
            rdreg(2'd0, "R2");
        end
        rdreg(2'd1, "R12");

        // R4 / R7 / R5: fill, overflow, simultaneous push+pop
        for (int i = 0; i < DEPTH; i++) push(8'(i + 8'h80), 3'(i % 8), "R3");
        rdreg(2'd2, "R3");
        push(8'hEE, 3'b111, "R4");
        rdreg(2'd2, "R4");
        cyc(1'b1, 8'hD7, 3'b010, 1'b1, 2'd0, 1'b0, "R7");
        rdreg(2'd1, "R5");
        rdreg(2'd1, "R5");
        cyc(1'b1, 8'hEF, 3'b000, 1'b1, 2'd1, 1'b0, "R5");
        rdreg(2'd1, "R5");
        for (int i = 0; i < DEPTH; i++) begin
            rdreg(2'd1, "R12");
            rdreg(2'd0, "R2");
        end
        rdreg(2'd0, "R6");
        rdreg(2'd0, "R6");
        rdreg(2'd2, "R6");

        // R8: legacy threshold table
        for (int s = 0; s < 4; s++) begin
            trig_legacy = 2'(s);
            rdreg(2'd3, "R8");
            for (int i = 0; i < 30; i++) push(8'(i), 3'b000, "R8");
            flush("R8");
        end

        // R9: programmed threshold, zero acts as one
        trig_prog_en = 1'b1;
        int_trig = 6'd0;
        rdreg(2'd3, "R9");
        push(8'h11, 3'b000, "R9");
        flush("R9");
        int_trig = 6'd5;
        rdreg(2'd3, "R9");
        for (int i = 0; i < 7; i++) push(8'(i), 3'b000, "R9");
        int_trig = 6'd20;
        rdreg(2'd3, "R9");
        flush("R9");

        // R10: flow threshold
        flow_trig = 6'd10;
        for (int i = 0; i < 12; i++) push(8'(i), 3'b000, "R10");
        for (int i = 0; i < 4; i++) rdreg(2'd0, "R10");
        flush("R10");

        // R11: flush priority, overrun preserved
        for (int i = 0; i < DEPTH; i++) push(8'(i), 3'b000, "R11");
        push(8'h99, 3'b000, "R11");
        cyc(1'b1, 8'h55, 3'b001, 1'b0, 2'd0, 1'b1, "R11");
        rdreg(2'd0, "R11");
        rdreg(2'd1, "R11");
        rdreg(2'd1, "R11");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule